// File: doc/BRIEF.md
# Sector Continuity Stop Controller

This block sits after the error-correction stages of an optical-disc data decoder and decides when sector decoding has to halt. Each sector arrives with a one-cycle valid strobe that carries its minute/second/frame address in BCD, its mode and form, and two flags from upstream. One flag reports an error that correction could not repair. The other reports that the detection check run after correction failed. The block compares every sector with the one accepted before it. It raises a sticky halt whenever a stop condition occurs whose enable bit is set, and it records which condition caused the halt.

There are four stop conditions, each with its own enable bit: an uncorrectable error, a failed post-correction check, a change of mode or form, and a break in address continuity. Software writes the enables through a small write port. A write is held in a shadow copy, and that copy becomes active only at a sector boundary, so a sector is always judged under a single set of enables. A restart pulse clears the halt and its cause. It also makes the next sector a fresh reference. A per-sector status vector reports all four raw conditions, whatever the enable bits say.

Top module: `sector_stop_ctrl`

## Requirements
- R1: After reset, `halt` is 0, `halt_cause` is 0, `sec_status` is 0, and both the written and the active enable sets are all zero.
- R2: If the active enable bit 0 is set and a sector is accepted with `ecc_fail` high, `halt` goes to 1 and `halt_cause` becomes 4'b0001. Both are visible one cycle after the strobe. A sector is accepted when `sec_valid` is high and `restart` is low.
- R3: If the active enable bit 1 is set and an accepted sector has `edc_fail` high, `halt` rises and `halt_cause` becomes 4'b0010, one cycle after the strobe.
- R4: If the active enable bit 2 is set and the {`sec_mode`,`sec_form`} of an accepted sector differs from that of the previously accepted sector, `halt` rises and `halt_cause` becomes 4'b0100.
- R5: The expected address is derived from the previously accepted sector, with every field in two-digit BCD. Frames advance by one and wrap from 0x74 to 0x00, carrying into seconds. Seconds wrap from 0x59 to 0x00, carrying into minutes. Minutes wrap from 0x99 to 0x00. If the active enable bit 3 is set and the received address differs from the expected one, `halt` rises and `halt_cause` becomes 4'b1000.
- R6: The first sector accepted after reset or after a restart skips both continuity checks, so its status bits 2 and 3 are 0. It only sets the reference for the next sector.
- R7: A `cfg_we` write stores `cfg_wdata` as pending enables only. The pending set is copied into the active set at every accepted strobe, after that sector has been judged, and also on `restart`. A write made before a strobe therefore does not affect that sector.
- R8: A condition whose active enable bit is clear never raises `halt`. One cycle after each accepted strobe, `sec_status` shows all four raw conditions of that sector: bit 0 uncorrectable, bit 1 check failed, bit 2 mode/form change, bit 3 address break. The vector is not sticky, and it changes only on an accepted strobe.
- R9: Once set, `halt` and `halt_cause` hold through later sectors. A `restart` pulse clears both one cycle later. It takes priority over a strobe in the same cycle, and that strobe is discarded.
- R10: When several enabled conditions occur in the same sector, `halt_cause` is one-hot and the winner follows the priority uncorrectable > check failed > mode/form > address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the pending enable set |
| cfg_wdata | input | 4 | Enables: bit0 uncorrectable, bit1 check failed, bit2 mode/form, bit3 address |
| restart | input | 1 | Clears halt and cause, restarts the reference, loads the enables |
| sec_valid | input | 1 | One-cycle strobe: header and flags are stable |
| sec_min | input | 8 | BCD minutes |
| sec_sec | input | 8 | BCD seconds |
| sec_frm | input | 8 | BCD frames (0x00 to 0x74) |
| sec_mode | input | MODE_W | Sector mode |
| sec_form | input | 1 | Sector form |
| ecc_fail | input | 1 | Correction left errors unrepaired |
| edc_fail | input | 1 | Post-correction check failed |
| halt | output | 1 | Sticky stop request |
| halt_cause | output | 4 | One-hot cause of the halt, same bit order as cfg_wdata |
| sec_status | output | 4 | Raw conditions of the last accepted sector |

## Verification
Every result is registered once, so `halt`, `halt_cause` and `sec_status` are all due exactly one cycle after the accepted strobe. The enable set written by software first applies to the sector after the next accepted strobe. The driver raises the strobe on a falling edge and pushes the expected result into a queue. The monitor records at the following rising edge that a sector was accepted, then pops and compares on the falling edge that follows, which is the one cycle the results are due. Restart effects are checked directly on the falling edge after the restart cycle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   localparam int NCAUSE = 4;
   localparam int C_ECC  = 0;
   localparam int C_EDC  = 1;
   localparam int C_MODE = 2;
   localparam int C_ADDR = 3;

   function automatic logic [7:0] to_bcd(input int n);
      return {4'(n / 10), 4'(n % 10)};
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction
endpackage

// File: rtl/ssc_bcd_step.sv
module ssc_bcd_step #(
   parameter int LIMIT = 75
) (
   input  logic [7:0] cur,
   input  logic       carry_in,
   output logic [7:0] nxt,
   output logic       carry_out
);
   localparam logic [7:0] LAST = ssc_pkg::to_bcd(LIMIT - 1);

   initial begin
      assert (LIMIT >= 2 && LIMIT <= 100)
         else $error("ssc_bcd_step: LIMIT must fit two BCD digits");
   end

   logic at_last;
   assign at_last   = (cur == LAST);
   assign carry_out = carry_in & at_last;

   always_comb begin
      if (!carry_in)    nxt = cur;
      else if (at_last) nxt = 8'h00;
      else              nxt = ssc_pkg::bcd_inc(cur);
   end
endmodule

// File: rtl/ssc_enable_shadow.sv
module ssc_enable_shadow #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [N-1:0] wdata,
   input  logic         load,
   output logic [N-1:0] act
);
   logic [N-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act    <= '0;
      end else begin
         if (wr)   pend_q <= wdata;
         if (load) act    <= pend_q;
      end
   end
endmodule

// File: rtl/ssc_cause_sel.sv
module ssc_cause_sel #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick
);
   always_comb begin
      logic found;
      found = 1'b0;
      pick  = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            pick[i] = 1'b1;
            found   = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sector_stop_ctrl.sv
module sector_stop_ctrl #(
   parameter int MODE_W         = 2,
   parameter int FRAMES_PER_SEC = 75,
   parameter int SECS_PER_MIN   = 60,
   parameter int MINS_PER_WRAP  = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_wdata,
   input  logic              restart,
   input  logic              sec_valid,
   input  logic [7:0]        sec_min,
   input  logic [7:0]        sec_sec,
   input  logic [7:0]        sec_frm,
   input  logic [MODE_W-1:0] sec_mode,
   input  logic              sec_form,
   input  logic              ecc_fail,
   input  logic              edc_fail,
   output logic              halt,
   output logic [3:0]        halt_cause,
   output logic [3:0]        sec_status
);
   import ssc_pkg::*;

   localparam int NC    = NCAUSE;
   localparam int MF_W  = MODE_W + 1;
   localparam int NFLD  = 3;
   localparam int LIMS [NFLD] = '{FRAMES_PER_SEC, SECS_PER_MIN, MINS_PER_WRAP};

   initial begin
      assert (MODE_W >= 1) else $error("sector_stop_ctrl: MODE_W must be at least 1");
      assert (NC == 4) else $error("sector_stop_ctrl: cause vector must be 4 bits");
   end

   logic                accept;
   logic [NC-1:0]       act_en;
   logic [NC-1:0]       raw;
   logic [NC-1:0]       armed;
   logic [NC-1:0]       pick;
   logic [MF_W-1:0]     cur_mf;
   logic [MF_W-1:0]     ref_mf_q;
   logic [NFLD-1:0][7:0] cur_f;
   logic [NFLD-1:0][7:0] ref_f_q;
   logic [NFLD-1:0][7:0] exp_f;
   logic                have_ref_q;

   assign accept = sec_valid & ~restart;
   assign cur_mf = {sec_mode, sec_form};
   assign cur_f  = {sec_min, sec_sec, sec_frm};

   ssc_enable_shadow #(.N(NC)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_we),
      .wdata (cfg_wdata),
      .load  (accept | restart),
      .act   (act_en)
   );

   for (genvar g = 0; g < NFLD; g++) begin : g_step
      logic ci;
      logic co;
      if (g == 0) begin : g_first
         assign ci = 1'b1;
      end else begin : g_next
         assign ci = g_step[g-1].co;
      end
      ssc_bcd_step #(.LIMIT(LIMS[g])) u_step (
         .cur       (ref_f_q[g]),
         .carry_in  (ci),
         .nxt       (exp_f[g]),
         .carry_out (co)
      );
   end

   always_comb begin
      raw         = '0;
      raw[C_ECC]  = ecc_fail;
      raw[C_EDC]  = edc_fail;
      raw[C_MODE] = have_ref_q && (cur_mf != ref_mf_q);
      raw[C_ADDR] = have_ref_q && (cur_f != exp_f);
   end

   assign armed = raw & act_en;

   ssc_cause_sel #(.N(NC)) u_sel (
      .req  (armed),
      .pick (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt       <= 1'b0;
         halt_cause <= '0;
         sec_status <= '0;
         ref_f_q    <= '0;
         ref_mf_q   <= '0;
         have_ref_q <= 1'b0;
      end else if (restart) begin
         halt       <= 1'b0;
         halt_cause <= '0;
         have_ref_q <= 1'b0;
      end else if (sec_valid) begin
         sec_status <= raw;
         ref_f_q    <= cur_f;
         ref_mf_q   <= cur_mf;
         have_ref_q <= 1'b1;
         if (!halt && (|armed)) begin
            halt       <= 1'b1;
            halt_cause <= pick;
         end
      end
   end
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
   parameter int NC = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          restart,
   input logic          sec_valid,
   input logic          halt,
   input logic [NC-1:0] halt_cause,
   input logic [NC-1:0] sec_status,
   input logic [NC-1:0] act_en
);
   p_idle_no_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !halt |-> (halt_cause == '0));

   p_rise_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> $past(sec_valid && !restart));

   p_stop_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt) |-> ((halt_cause & $past(act_en)) != '0));

   p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_valid || restart) |=> $stable(sec_status));

   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !restart) |=> (halt && $stable(halt_cause)));

   p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!halt && halt_cause == '0));

   p_cause_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> ($countones(halt_cause) == 1));
endmodule

bind sector_stop_ctrl ssc_checker #(.NC(4)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (restart),
   .sec_valid  (sec_valid),
   .halt       (halt),
   .halt_cause (halt_cause),
   .sec_status (sec_status),
   .act_en     (act_en)
);

// File: tb/sector_stop_ctrl_tb_top.sv
module sector_stop_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_wdata = '0;
   logic       restart = 1'b0;
   logic       sec_valid = 1'b0;
   logic [7:0] sec_min = '0, sec_sec = '0, sec_frm = '0;
   logic [1:0] sec_mode = '0;
   logic       sec_form = 1'b0;
   logic       ecc_fail = 1'b0, edc_fail = 1'b0;
   logic       halt;
   logic [3:0] halt_cause, sec_status;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   sector_stop_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .restart(restart), .sec_valid(sec_valid), .sec_min(sec_min),
      .sec_sec(sec_sec), .sec_frm(sec_frm), .sec_mode(sec_mode),
      .sec_form(sec_form), .ecc_fail(ecc_fail), .edc_fail(edc_fail),
      .halt(halt), .halt_cause(halt_cause), .sec_status(sec_status)
   );

   // bench-side model state
   logic       m_halt = 0;
   logic [3:0] m_cause = 0, m_status = 0, m_act = 0, m_pend = 0;
   logic       m_have = 0;
   logic [7:0] m_min = 0, m_sec = 0, m_frm = 0;
   logic [2:0] m_mf = 0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   task automatic chk(string req, logic [8:0] act, logic [8:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual halt/cause/status=%b expected=%b", req, act, expv);
      end
   endtask

   function automatic int b2i(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2b(int n);
      return {4'(n / 10), 4'(n % 10)};
   endfunction

   task automatic send(string req, logic [7:0] mi, logic [7:0] se, logic [7:0] fr,
                       logic [1:0] md, logic fm, logic ec, logic ed);
      int f, s, m;
      logic [3:0] raw;
      logic [3:0] arm;
      f = b2i(m_frm) + 1; s = b2i(m_sec); m = b2i(m_min);
      if (f == 75) begin f = 0; s++; end
      if (s == 60) begin s = 0; m++; end
      if (m == 100) m = 0;
      raw = {m_have && ({mi, se, fr} != {i2b(m), i2b(s), i2b(f)}),
             m_have && ({md, fm} != m_mf), ed, ec};
      arm = raw & m_act;
      if (!m_halt && arm != 0) begin
         m_halt = 1;
         if (arm[0]) m_cause = 4'b0001;
         else if (arm[1]) m_cause = 4'b0010;
         else if (arm[2]) m_cause = 4'b0100;
         else m_cause = 4'b1000;
      end
      m_status = raw;
      m_min = mi; m_sec = se; m_frm = fr; m_mf = {md, fm}; m_have = 1;
      m_act = m_pend;
      exp_q.push_back({m_halt, m_cause, m_status});
      tag_q.push_back(req);
      @(negedge clk);
      sec_min = mi; sec_sec = se; sec_frm = fr; sec_mode = md; sec_form = fm;
      ecc_fail = ec; edc_fail = ed; sec_valid = 1;
      @(negedge clk);
      sec_valid = 0; ecc_fail = 0; edc_fail = 0;
   endtask

   task automatic write_en(logic [3:0] v);
      @(negedge clk);
      cfg_we = 1; cfg_wdata = v; m_pend = v;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic do_restart(logic with_strobe);
      @(negedge clk);
      restart = 1; sec_valid = with_strobe; ecc_fail = with_strobe;
      m_halt = 0; m_cause = 0; m_have = 0; m_act = m_pend;
      @(negedge clk);
      restart = 0; sec_valid = 0; ecc_fail = 0;
      chk("R9 restart clears", {halt, halt_cause, sec_status}, {m_halt, m_cause, m_status});
   endtask

   // monitor: note accepted strobes at the rising edge, compare on the next falling edge
   logic seen = 0;
   always @(posedge clk) seen <= rst_n && sec_valid && !restart;
   always @(negedge clk) begin
      if (seen) begin
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R8 unexpected result actual=%b expected=none",
                     {halt, halt_cause, sec_status});
         end else begin
            string t;
            logic [8:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {halt, halt_cause, sec_status}, e);
         end
      end
   end

   initial begin
      #(8 * 150000);
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset state", {halt, halt_cause, sec_status}, 9'b0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after release", {halt, halt_cause, sec_status}, 9'b0);

      // all enables off: raw conditions only in status
      send("R6 first sector", 8'h00, 8'h02, 8'h00, 2'd1, 0, 0, 0);
      send("R5 sequential", 8'h00, 8'h02, 8'h01, 2'd1, 0, 0, 0);
      send("R8 ecc disabled", 8'h00, 8'h02, 8'h02, 2'd1, 0, 1, 0);
      send("R8 addr disabled", 8'h00, 8'h02, 8'h09, 2'd2, 1, 0, 1);
      send("R8 status clears", 8'h00, 8'h02, 8'h10, 2'd2, 1, 0, 0);

      // deferral of enables
      write_en(4'b1001);
      send("R7 write deferred", 8'h00, 8'h02, 8'h11, 2'd2, 1, 1, 0);
      send("R2 ecc stop", 8'h00, 8'h02, 8'h12, 2'd2, 1, 1, 0);
      send("R9 cause held", 8'h00, 8'h02, 8'h40, 2'd0, 0, 0, 1);
      do_restart(0);

      // BCD wraps
      send("R6 first after restart", 8'h00, 8'h02, 8'h74, 2'd0, 0, 0, 0);
      send("R5 frame wrap", 8'h00, 8'h03, 8'h00, 2'd0, 0, 0, 0);
      do_restart(0);
      send("R6 ref only", 8'h00, 8'h59, 8'h74, 2'd0, 0, 0, 0);
      send("R5 second wrap", 8'h01, 8'h00, 8'h00, 2'd0, 0, 0, 0);
      do_restart(0);
      send("R6 ref only", 8'h99, 8'h59, 8'h74, 2'd0, 0, 0, 0);
      send("R5 minute wrap", 8'h00, 8'h00, 8'h00, 2'd0, 0, 0, 0);
      send("R5 address break", 8'h00, 8'h00, 8'h02, 2'd0, 0, 0, 0);

      // mode stop; enables loaded at restart
      write_en(4'b1111);
      do_restart(0);
      send("R6 mode first", 8'h10, 8'h00, 8'h00, 2'd2, 0, 0, 0);
      send("R4 form change", 8'h10, 8'h00, 8'h01, 2'd2, 1, 0, 0);
      do_restart(0);
      send("R6 base", 8'h10, 8'h00, 8'h05, 2'd1, 0, 0, 0);
      send("R10 priority", 8'h10, 8'h00, 8'h30, 2'd2, 0, 1, 1);
      do_restart(0);
      send("R3 edc stop", 8'h20, 8'h00, 8'h00, 2'd1, 0, 0, 1);

      // restart beats a simultaneous strobe
      do_restart(1);
      send("R9 strobe discarded, R6 first", 8'h33, 8'h33, 8'h33, 2'd3, 1, 0, 0);
      send("R4 mode stop", 8'h33, 8'h33, 8'h34, 2'd0, 1, 0, 0);

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R8 missing results actual=%0d expected=0", exp_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule